// File: doc/BRIEF.md
# Three-Modulus Residue to Mixed-Radix Digit Converter

This block turns a number held as three residues into its three mixed-radix digits. The moduli are fixed to the special family m1 = 2^N+1, m2 = 2^N and m3 = 2^N-1, in that order. The block is purely combinational: the digits appear in the same cycle as the residues. They are meant for range or sign checks and for rebuilding the binary value as e1 + e2·m1 + e3·m1·m2.

Because the moduli have this special form, every modular multiply by a constant becomes something cheap. Multiplying by 2^(N-1) modulo 2^N-1 is a one-bit right rotation. Negating modulo 2^N-1 is a bitwise complement. The single odd case, a first residue equal to 2^N, is served by a small N-bit select. Adders then finish the job. The modulo 2^N-1 adder uses end-around carry, and the all-ones code is folded back to zero.

Top module: `rns_mrd_conv`

## Requirements
- R1: Output e1_o equals input x1_i on all N+1 bits, for every legal x1_i in 0..2^N.
- R2: Output e2_o equals (x2_i - x1_i) mod 2^N. Only bits N-1..0 of x1_i take part, so when x1_i = 2^N, e2_o equals x2_i.
- R3: Output e3_o equals (2^(N-1)·(x3_i - x1_i) - e2_o) mod (2^N-1).
- R4: Output e3_o is canonical. It is never the all-ones code and always lies in 0..2^N-2.
- R5: When bit N of x1_i is set (x1_i = 2^N), e3_o still meets R3. The term for x1_i in that case is the constant with 0 in bit N-1 and ones in bits N-2..0.
- R6: For every legal residue triple, e1_o + e2_o·(2^N+1) + e3_o·(2^N+1)·2^N equals the unique X in [0, M) with those residues, where M = (2^N+1)·2^N·(2^N-1).
- R7: The outputs depend on the present inputs only and settle in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x1_i | input | N+1 | Residue modulo 2^N+1, legal range 0..2^N |
| x2_i | input | N | Residue modulo 2^N |
| x3_i | input | N | Residue modulo 2^N-1, legal range 0..2^N-2 |
| e1_o | output | N+1 | Lowest mixed-radix digit, weight 1 |
| e2_o | output | N | Middle digit, weight 2^N+1 |
| e3_o | output | N | Top digit, weight (2^N+1)·2^N |

## Verification
The bench runs every legal residue triple for N = 2 and for N = 3. That sweep includes x1 = 2^N, which must take the constant select. A design that rotated the complement of the low bits there would be wrong in e3 for exactly those triples. Triples where the three-operand sum lands on 2^N-1 are also covered. There, a missing fold would emit the all-ones code, and a missing end-around carry would drop one unit from e3. Every triple is checked against a brute-force reverse search, and the digits must rebuild the searched value. A wrong borrow in the mod 2^N subtraction, or use of bit N of x1, therefore shows up as a mismatched X.

// File: rtl/rns_mrd_pkg.sv
// Shared constants for the residue to mixed-radix digit converter.
// Assumes the moduli family 2^N+1, 2^N, 2^N-1 with N > 1.
package rns_mrd_pkg;
    // Default digit width used when the top is elaborated on its own.
    localparam int unsigned MRD_N_DEFAULT = 4;
    // Smallest width for which the moduli family stays pairwise coprime
    // and the rotation identities hold.
    localparam int unsigned MRD_N_MIN = 2;
endpackage

// File: rtl/rns_mrd_sub_pow2.sv
// Computes the middle digit (x2 - x1) mod 2^N as x2 + ~x1 + 1.
// Assumes only the low N bits of x1 are supplied; the overflow bit is dropped.
module rns_mrd_sub_pow2 #(
    parameter int unsigned N = rns_mrd_pkg::MRD_N_DEFAULT
) (
    input  logic [N-1:0] minuend_i,
    input  logic [N-1:0] subtrahend_i,
    output logic [N-1:0] diff_o
);
    logic [N-1:0] neg_sub;

    // Two's-complement negation of the subtrahend, modulo 2^N.
    always_comb begin
        neg_sub = ~subtrahend_i + {{(N-1){1'b0}}, 1'b1};
    end

    // Modulo 2^N addition: the carry out of bit N-1 is discarded.
    always_comb begin
        diff_o = minuend_i + neg_sub;
    end
endmodule

// File: rtl/rns_mrd_term_gen.sv
// Builds the three operands for the top digit, each taken modulo 2^N-1:
//   half_x3  = 2^(N-1)*x3      (one-bit right rotation)
//   nhalf_x1 = -2^(N-1)*x1     (rotated complement, or a constant when x1 = 2^N)
//   neg_e2   = -e2             (bitwise complement)
// Assumes x1 is at most 2^N, so bit N set means the low bits are zero.
module rns_mrd_term_gen #(
    parameter int unsigned N = rns_mrd_pkg::MRD_N_DEFAULT
) (
    input  logic [N:0]   x1_i,
    input  logic [N-1:0] x3_i,
    input  logic [N-1:0] e2_i,
    output logic [N-1:0] half_x3_o,
    output logic [N-1:0] nhalf_x1_o,
    output logic [N-1:0] neg_e2_o
);
    localparam logic [N-1:0] TOP_CASE_CONST = {1'b0, {(N-1){1'b1}}};

    logic [N-1:0] x1_lo_inv;
    logic [N-1:0] x1_rot;

    // Inverted low bits of x1: the modulo 2^N-1 negation before scaling.
    always_comb begin
        x1_lo_inv = ~x1_i[N-1:0];
    end

    // Right rotations by one position are pure wiring, one bit per loop step.
    for (genvar b = 0; b < N; b++) begin : g_rot
        if (b == N - 1) begin : g_wrap
            assign half_x3_o[b] = x3_i[0];
            assign x1_rot[b]    = x1_lo_inv[0];
        end else begin : g_shift
            assign half_x3_o[b] = x3_i[b+1];
            assign x1_rot[b]    = x1_lo_inv[b+1];
        end
    end

    // Pick the constant term when x1 equals 2^N, else the rotated complement.
    always_comb begin
        nhalf_x1_o = x1_i[N] ? TOP_CASE_CONST : x1_rot;
    end

    // Negation of e2 modulo 2^N-1.
    always_comb begin
        neg_e2_o = ~e2_i;
    end
endmodule

// File: rtl/rns_mrd_add3_m3.sv
// Adds three N-bit operands modulo 2^N-1 and returns a canonical result.
// Stage one is a carry-save layer whose carry vector wraps around.
// Stage two is an end-around-carry adder. An all-ones result is folded to zero.
// Assumes each operand is an N-bit code whose value is taken mod 2^N-1.
module rns_mrd_add3_m3 #(
    parameter int unsigned N = rns_mrd_pkg::MRD_N_DEFAULT
) (
    input  logic [N-1:0] op_a_i,
    input  logic [N-1:0] op_b_i,
    input  logic [N-1:0] op_c_i,
    output logic [N-1:0] sum_o
);
    logic [N-1:0] csa_sum;
    logic [N-1:0] csa_cy;
    logic [N-1:0] csa_cy_wrap;
    logic [N:0]   raw_sum;
    logic [N-1:0] eac_sum;

    // Carry-save layer: one full adder per bit; the carry weight 2^N wraps to 1.
    for (genvar b = 0; b < N; b++) begin : g_csa
        assign csa_sum[b] = op_a_i[b] ^ op_b_i[b] ^ op_c_i[b];
        assign csa_cy[b]  = (op_a_i[b] & op_b_i[b]) | (op_a_i[b] & op_c_i[b])
                          | (op_b_i[b] & op_c_i[b]);
        if (b == 0) begin : g_wrap
            assign csa_cy_wrap[b] = csa_cy[N-1];
        end else begin : g_shift
            assign csa_cy_wrap[b] = csa_cy[b-1];
        end
    end

    // Carry-propagate addition of the two vectors with a spare carry bit.
    always_comb begin
        raw_sum = {1'b0, csa_sum} + {1'b0, csa_cy_wrap};
    end

    // End-around carry: the carry out has weight 2^N, which is 1 mod 2^N-1.
    always_comb begin
        eac_sum = raw_sum[N-1:0] + {{(N-1){1'b0}}, raw_sum[N]};
    end

    // All-ones is a second code for zero; map it to the canonical zero.
    always_comb begin
        sum_o = (&eac_sum) ? '0 : eac_sum;
    end
endmodule

// File: rtl/rns_mrd_conv.sv
// Converts residues modulo (2^N+1, 2^N, 2^N-1) to mixed-radix digits, where
// the value is e1 + e2*(2^N+1) + e3*(2^N+1)*2^N. The block is fully combinational.
// Assumes N > 1, x1 in 0..2^N and x3 in 0..2^N-2.
module rns_mrd_conv #(
    parameter int unsigned N = rns_mrd_pkg::MRD_N_DEFAULT
) (
    input  logic [N:0]   x1_i,
    input  logic [N-1:0] x2_i,
    input  logic [N-1:0] x3_i,
    output logic [N:0]   e1_o,
    output logic [N-1:0] e2_o,
    output logic [N-1:0] e3_o
);
    logic [N-1:0] e2_w;
    logic [N-1:0] half_x3;
    logic [N-1:0] nhalf_x1;
    logic [N-1:0] neg_e2;

    // The lowest digit is the first residue itself.
    always_comb begin
        e1_o = x1_i;
    end

    // Middle digit: the inverse of m1 modulo m2 is 1, so this is a plain difference.
    rns_mrd_sub_pow2 #(.N(N)) u_sub (
        .minuend_i    (x2_i),
        .subtrahend_i (x1_i[N-1:0]),
        .diff_o       (e2_w)
    );

    // Operand routing for the top digit.
    rns_mrd_term_gen #(.N(N)) u_terms (
        .x1_i       (x1_i),
        .x3_i       (x3_i),
        .e2_i       (e2_w),
        .half_x3_o  (half_x3),
        .nhalf_x1_o (nhalf_x1),
        .neg_e2_o   (neg_e2)
    );

    // Top digit: the three routed terms summed modulo 2^N-1.
    rns_mrd_add3_m3 #(.N(N)) u_add3 (
        .op_a_i (half_x3),
        .op_b_i (nhalf_x1),
        .op_c_i (neg_e2),
        .sum_o  (e3_o)
    );

    // Drive the middle digit output from the subtractor.
    always_comb begin
        e2_o = e2_w;
    end
endmodule

// File: rtl/rns_mrd_conv_chk.sv
// Assertion checker for the converter, bound to every instance of the top.
// It checks the digits through inverse relations, never by re-deriving them.
module rns_mrd_conv_chk #(
    parameter int unsigned N = rns_mrd_pkg::MRD_N_DEFAULT
) (
    input logic [N:0]   x1_i,
    input logic [N-1:0] x2_i,
    input logic [N-1:0] x3_i,
    input logic [N:0]   e1_o,
    input logic [N-1:0] e2_o,
    input logic [N-1:0] e3_o
);
    localparam int M3 = (1 << N) - 1;
    localparam int P2 = 1 << N;

    logic [N-1:0] e2_plus_x1;
    logic         x1_legal;
    int           mod3_image;

    // Add the subtrahend back to e2; the result must reproduce x2 modulo 2^N.
    always_comb begin
        e2_plus_x1 = e2_o + x1_i[N-1:0];
    end

    // Legal first residue and the mod m3 image of the rebuilt value (m1, m1*m2 = 2 mod m3).
    always_comb begin
        x1_legal   = (int'(x1_i) <= P2);
        mod3_image = (int'(e1_o) + 2 * int'(e2_o) + 2 * int'(e3_o)) % M3;
    end

    // Immediate checks on the settled combinational outputs.
    always_comb begin
        a_r2_e2_inverse: assert (e2_plus_x1 == x2_i)
            else $error("R2: e2 plus x1 does not give x2");
        a_r4_e3_canonical: assert (!(&e3_o))
            else $error("R4: e3 holds the all-ones code");
        if (x1_legal) begin
            a_r3_mod_m3_image: assert (mod3_image == (int'(x3_i) % M3))
                else $error("R3: rebuilt value mod m3 differs from x3");
        end
        if (x1_i[N]) begin
            a_r5_top_case_e2: assert (e2_o == x2_i)
                else $error("R5: x1 = 2^N changed e2");
        end
    end
endmodule

bind rns_mrd_conv rns_mrd_conv_chk #(.N(N)) u_chk (
    .x1_i (x1_i),
    .x2_i (x2_i),
    .x3_i (x3_i),
    .e1_o (e1_o),
    .e2_o (e2_o),
    .e3_o (e3_o)
);

// File: tb/tb_rns_mrd_conv.sv
module tb_rns_mrd_conv;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    // Instance at N = 3.
    logic [3:0] a_x1 = '0;
    logic [2:0] a_x2 = '0;
    logic [2:0] a_x3 = '0;
    logic [3:0] a_e1;
    logic [2:0] a_e2;
    logic [2:0] a_e3;

    rns_mrd_conv #(.N(3)) dut (
        .x1_i(a_x1), .x2_i(a_x2), .x3_i(a_x3),
        .e1_o(a_e1), .e2_o(a_e2), .e3_o(a_e3)
    );

    // Instance at N = 2.
    logic [2:0] b_x1 = '0;
    logic [1:0] b_x2 = '0;
    logic [1:0] b_x3 = '0;
    logic [2:0] b_e1;
    logic [1:0] b_e2;
    logic [1:0] b_e3;

    rns_mrd_conv #(.N(2)) dut_n2 (
        .x1_i(b_x1), .x2_i(b_x2), .x3_i(b_x3),
        .e1_o(b_e1), .e2_o(b_e2), .e3_o(b_e3)
    );

    task automatic chk(input string tag, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    // Behavioural reference: search X by residues, then split it into digits.
    task automatic check_triple(input int n, input int x1, input int x2, input int x3,
                                input int e1, input int e2, input int e3);
        int m1 = (1 << n) + 1;
        int m2 = 1 << n;
        int m3 = (1 << n) - 1;
        int xv = -1;
        int rebuilt;
        for (int v = 0; v < m1 * m2 * m3; v++) begin
            if ((v % m1 == x1) && (v % m2 == x2) && (v % m3 == x3)) xv = v;
        end
        chk("R1", e1, xv % m1, "e1 digit");
        chk("R2", e2, (xv / m1) % m2, "e2 digit");
        if (x1 == m2) chk("R5", e3, xv / (m1 * m2), "e3 with x1=2^N");
        else          chk("R3", e3, xv / (m1 * m2), "e3 digit");
        chk("R4", int'(e3 == m3), 0, "e3 all-ones flag");
        rebuilt = e1 + e2 * m1 + e3 * m1 * m2;
        chk("R6", rebuilt, xv, "rebuilt value");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: all-zero inputs give all-zero digits in the same cycle.
        chk("R7", int'(a_e1) + int'(a_e2) + int'(a_e3), 0, "zero input digits n3");
        chk("R7", int'(b_e1) + int'(b_e2) + int'(b_e3), 0, "zero input digits n2");
        for (int x1 = 0; x1 <= 8; x1++) begin
            for (int x2 = 0; x2 < 8; x2++) begin
                for (int x3 = 0; x3 < 7; x3++) begin
                    @(posedge clk);
                    #2;
                    a_x1 = 4'(x1); a_x2 = 3'(x2); a_x3 = 3'(x3);
                    @(negedge clk);
                    check_triple(3, x1, x2, x3, int'(a_e1), int'(a_e2), int'(a_e3));
                end
            end
        end
        for (int x1 = 0; x1 <= 4; x1++) begin
            for (int x2 = 0; x2 < 4; x2++) begin
                for (int x3 = 0; x3 < 3; x3++) begin
                    @(posedge clk);
                    #2;
                    b_x1 = 3'(x1); b_x2 = 2'(x2); b_x3 = 2'(x3);
                    @(negedge clk);
                    check_triple(2, x1, x2, x3, int'(b_e1), int'(b_e2), int'(b_e3));
                end
            end
        end
        // R7: a change of inputs appears without waiting for a clock edge.
        a_x1 = 4'd8; a_x2 = 3'd5; a_x3 = 3'd0;
        #1;
        chk("R7", int'(a_e2), 5, "same-cycle e2 after input change");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: counts as a failed check and still prints the summary line.
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R7 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule